// File: doc/BRIEF.md
# Across-Track Banded Viterbi Detector

This block makes maximum-likelihood bit decisions across a band of eight adjacent tracks. At one bit position it takes one sample from each track, in track order, and treats them as consecutive symbols of a four-state trellis. The trellis target is the three-tap inter-track interference response, so the samples need no equalisation across tracks. Each state keeps its decided bits by register exchange. A path history is copied from the winning predecessor and the new bit is shifted in.

No decision leaves the block while a band is in progress. When the sample of the last track has been accepted, the block picks the state with the lowest metric and delivers that state's full history as an 8-bit word, with a one-cycle valid strobe. Every band starts again from the all-zero state. The three target taps are held in writable registers. The reference levels for all eight branch patterns are derived from the taps and kept in registers, so the branch arithmetic only subtracts and squares.

Top module: `atv_band_detector`

## Requirements
- R1: After reset, out_valid and out_word are 0 and the taps hold h0=3, h1=5, h2=3, so a band can be decoded before any tap write.
- R2: A cycle with cfg_we high and cfg_sel equal to 0, 1 or 2 loads cfg_data into h0, h1 or h2. cfg_sel=3 changes nothing. A tap write applies to samples accepted from the second clock edge after the write edge.
- R3: A bit of 1 maps to symbol +1 and a bit of 0 maps to symbol -1. The expected level at track t is h0·a(t) + h1·a(t-1) + h2·a(t-2). Positions before track 0 count as bit 0, because the trellis starts each band in the all-zero state.
- R4: With h0 non-zero and samples equal to the expected levels of some word, the decoded word equals that word.
- R5: For any samples, the decoded word minimises the sum over the 8 tracks of (sample − expected level)².
- R6: Bit t of out_word is the decision for track t, so bit 0 belongs to the first track of the band.
- R7: out_valid is high for exactly one cycle: the cycle after the clock edge that accepts a sample with in_track=7. No other track raises it.
- R8: Cycles with in_valid low have no effect on the result. out_word holds its value between valid strobes.
- R9: An accepted sample with in_track=0 discards any partial band and starts a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Tap write strobe |
| cfg_sel | input | 2 | Tap select: 0 = h0, 1 = h1, 2 = h2 |
| cfg_data | input | 8 | Signed tap value |
| in_valid | input | 1 | Sample present this cycle |
| in_track | input | 3 | Track index of the sample within the band |
| in_sample | input | 8 | Signed sample |
| out_valid | output | 1 | One-cycle strobe for a decoded band |
| out_word | output | 8 | Decoded band, bit t for track t |

## Verification
The decoded word and its strobe are due one clock edge after the edge that accepts the track-7 sample. The bench therefore drives inputs on falling edges and reads out_valid and out_word at the falling edge that follows that acceptance, and again one cycle later to confirm the strobe has dropped and the word is held. A tap write needs two edges before a band may use it, so the bench inserts two idle cycles after each write before it starts a band. Noise-free bands are compared bit for bit. Noisy bands are judged by an exhaustive search over all 256 words, which checks that the decoded word reaches the minimum path cost, so ties between equal-cost paths cannot cause false failures.

// File: rtl/atv_pkg.sv
package atv_pkg;
  localparam int SW     = 8;          // sample width
  localparam int TW     = 8;          // tap width
  localparam int RW     = TW + 2;     // reference level width (sum of three taps)
  localparam int MW     = 26;         // path metric width
  localparam int NSTATE = 4;          // two remembered bits
  localparam int NREF   = 2 * NSTATE; // one level per branch pattern

  // Metric given to states other than the start state; exceeds any real band cost.
  localparam logic [MW-1:0] START_PENALTY = MW'(1) << (MW - 4);

  function automatic int sym(input logic b, input int h);
    return b ? h : -h;
  endfunction

  // bits = {current, one track back, two tracks back}
  function automatic logic signed [RW-1:0] ref_level(input logic signed [TW-1:0] h0,
                                                     input logic signed [TW-1:0] h1,
                                                     input logic signed [TW-1:0] h2,
                                                     input logic [2:0] bits);
    int acc;
    acc = sym(bits[2], int'(h0)) + sym(bits[1], int'(h1)) + sym(bits[0], int'(h2));
    return RW'(acc);
  endfunction

  function automatic logic [MW-1:0] sq_dist(input logic signed [SW-1:0] x,
                                            input logic signed [RW-1:0] r);
    int d;
    d = int'(x) - int'(r);
    return MW'(d * d);
  endfunction
endpackage

// File: rtl/atv_tap_bank.sv
module atv_tap_bank
  import atv_pkg::*;
#(
  parameter logic signed [TW-1:0] H0_RST = 8'sd3,
  parameter logic signed [TW-1:0] H1_RST = 8'sd5,
  parameter logic signed [TW-1:0] H2_RST = 8'sd3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic signed [TW-1:0]      cfg_data,
  output logic [2:0][TW-1:0]        taps,
  output logic [NREF-1:0][RW-1:0]   ref_tab
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps[0] <= H0_RST;
      taps[1] <= H1_RST;
      taps[2] <= H2_RST;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    taps[0] <= cfg_data;
        2'd1:    taps[1] <= cfg_data;
        2'd2:    taps[2] <= cfg_data;
        default: ;
      endcase
    end
  end

  // Levels refreshed one edge after the taps change.
  for (genvar i = 0; i < NREF; i++) begin : g_ref
    always_ff @(posedge clk) begin
      if (!rst_n) ref_tab[i] <= ref_level(H0_RST, H1_RST, H2_RST, 3'(i));
      else        ref_tab[i] <= ref_level($signed(taps[0]), $signed(taps[1]),
                                          $signed(taps[2]), 3'(i));
    end
  end
endmodule

// File: rtl/atv_acs_array.sv
module atv_acs_array
  import atv_pkg::*;
#(
  parameter int NTRK = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step,
  input  logic                           first,
  input  logic signed [SW-1:0]           sample,
  input  logic [NREF-1:0][RW-1:0]        ref_tab,
  output logic [NSTATE-1:0][MW-1:0]      nxt_metric,
  output logic [NSTATE-1:0][NTRK-1:0]    nxt_hist,
  output logic [NSTATE-1:0][MW-1:0]      cur_metric,
  output logic [NSTATE-1:0]              pick_lower
);
  logic [NSTATE-1:0][MW-1:0]   src_metric;
  logic [NSTATE-1:0][NTRK-1:0] src_hist;
  logic [NSTATE-1:0][NTRK-1:0] hist_q;

  // A band start replaces the stored state by the all-zero start state.
  always_comb begin
    for (int s = 0; s < NSTATE; s++) begin
      if (first) src_metric[s] = (s == 0) ? '0 : START_PENALTY;
      else       src_metric[s] = cur_metric[s];
    end
    src_hist = first ? '0 : hist_q;
  end

  // State n = {newest bit, previous bit}; predecessors {previous, 0} and {previous, 1}.
  for (genvar n = 0; n < NSTATE; n++) begin : g_state
    localparam int X  = n / 2;
    localparam int M  = n % 2;
    localparam int UP = 2 * M;
    localparam int LO = 2 * M + 1;
    logic [MW-1:0]   bm_up, bm_lo;
    logic [NTRK-1:0] keep;
    assign bm_up         = src_metric[UP] + sq_dist(sample, $signed(ref_tab[2*n]));
    assign bm_lo         = src_metric[LO] + sq_dist(sample, $signed(ref_tab[2*n+1]));
    assign pick_lower[n] = bm_lo < bm_up;
    assign nxt_metric[n] = pick_lower[n] ? bm_lo : bm_up;
    assign keep          = pick_lower[n] ? src_hist[LO] : src_hist[UP];
    assign nxt_hist[n]   = {1'(X), keep[NTRK-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_metric <= '0;
      hist_q     <= '0;
    end else if (step) begin
      cur_metric <= nxt_metric;
      hist_q     <= nxt_hist;
    end
  end
endmodule

// File: rtl/atv_best_state.sv
module atv_best_state
  import atv_pkg::*;
#(
  parameter int NTRK = 8
) (
  input  logic [NSTATE-1:0][MW-1:0]   metric,
  input  logic [NSTATE-1:0][NTRK-1:0] hist,
  output logic [MW-1:0]               best_metric,
  output logic [NTRK-1:0]             best_hist
);
  // Lowest state index wins a tie.
  always_comb begin
    best_metric = metric[0];
    best_hist   = hist[0];
    for (int s = 1; s < NSTATE; s++) begin
      if (metric[s] < best_metric) begin
        best_metric = metric[s];
        best_hist   = hist[s];
      end
    end
  end
endmodule

// File: rtl/atv_band_detector.sv
module atv_band_detector
  import atv_pkg::*;
#(
  parameter int  NTRK = 8,
  localparam int IW   = $clog2(NTRK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic signed [TW-1:0] cfg_data,
  input  logic                 in_valid,
  input  logic [IW-1:0]        in_track,
  input  logic signed [SW-1:0] in_sample,
  output logic                 out_valid,
  output logic [NTRK-1:0]      out_word
);
  logic [2:0][TW-1:0]          taps;
  logic [NREF-1:0][RW-1:0]     ref_tab;
  logic [NSTATE-1:0][MW-1:0]   nxt_metric;
  logic [NSTATE-1:0][NTRK-1:0] nxt_hist;
  logic [NSTATE-1:0][MW-1:0]   cur_metric;
  logic [NSTATE-1:0]           pick_lower;
  logic [MW-1:0]               best_metric;
  logic [NTRK-1:0]             best_hist;
  logic                        band_first;
  logic                        band_last;
  logic                        band_done;

  assign band_first = (in_track == '0);
  assign band_last  = (in_track == IW'(NTRK - 1));
  assign band_done  = in_valid && band_last;

  atv_tap_bank u_taps (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .taps     (taps),
    .ref_tab  (ref_tab)
  );

  atv_acs_array #(.NTRK(NTRK)) u_acs (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (in_valid),
    .first      (band_first),
    .sample     (in_sample),
    .ref_tab    (ref_tab),
    .nxt_metric (nxt_metric),
    .nxt_hist   (nxt_hist),
    .cur_metric (cur_metric),
    .pick_lower (pick_lower)
  );

  atv_best_state #(.NTRK(NTRK)) u_best (
    .metric      (nxt_metric),
    .hist        (nxt_hist),
    .best_metric (best_metric),
    .best_hist   (best_hist)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= band_done;
      if (band_done) out_word <= best_hist;
    end
  end
endmodule

// File: rtl/atv_band_checker.sv
module atv_band_checker
  import atv_pkg::*;
#(
  parameter int NTRK = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [1:0]                   cfg_sel,
  input logic                         in_valid,
  input logic                         band_first,
  input logic                         band_last,
  input logic [2:0][TW-1:0]           taps,
  input logic [NSTATE-1:0][MW-1:0]    cur_metric,
  input logic [NSTATE-1:0][MW-1:0]    nxt_metric,
  input logic [MW-1:0]                best_metric,
  input logic                         out_valid,
  input logic [NTRK-1:0]              out_word
);
  a_r7_strobe_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && band_last) |=> out_valid);

  a_r7_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && band_last));

  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));

  a_r2_sel3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> $stable(taps));

  a_r3_band_starts_at_zero_state: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && band_first) |=>
      (cur_metric[1] >= START_PENALTY && cur_metric[3] >= START_PENALTY));

  a_r5_best_is_minimum: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && band_last) |->
      (best_metric <= nxt_metric[0] && best_metric <= nxt_metric[1] &&
       best_metric <= nxt_metric[2] && best_metric <= nxt_metric[3]));
endmodule

bind atv_band_detector atv_band_checker #(.NTRK(NTRK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .in_valid    (in_valid),
  .band_first  (band_first),
  .band_last   (band_last),
  .taps        (taps),
  .cur_metric  (cur_metric),
  .nxt_metric  (nxt_metric),
  .best_metric (best_metric),
  .out_valid   (out_valid),
  .out_word    (out_word)
);

// File: tb/atv_band_detector_bench.sv
module atv_band_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 8;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic signed [7:0] cfg_data = '0;
  logic              in_valid = 1'b0;
  logic [2:0]        in_track = '0;
  logic signed [7:0] in_sample = '0;
  logic              out_valid;
  logic [7:0]        out_word;

  int nchk = 0;
  int nfail = 0;
  int th0 = 3, th1 = 5, th2 = 3;
  int smp[NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  atv_band_detector u_atv_band_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .in_valid  (in_valid),
    .in_track  (in_track),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  // Expected level of track t for word w, bits before track 0 taken as 0.
  function automatic int lvl(int t, logic [7:0] w);
    int a0, a1, a2;
    a0 = w[t] ? 1 : -1;
    a1 = -1;
    a2 = -1;
    if (t >= 1) a1 = w[t-1] ? 1 : -1;
    if (t >= 2) a2 = w[t-2] ? 1 : -1;
    return th0 * a0 + th1 * a1 + th2 * a2;
  endfunction

  function automatic int cost(logic [7:0] w);
    int c = 0;
    for (int t = 0; t < NT; t++) c += (smp[t] - lvl(t, w)) * (smp[t] - lvl(t, w));
    return c;
  endfunction

  function automatic int best_cost();
    int b = cost(8'd0);
    for (int w = 1; w < 256; w++) if (cost(8'(w)) < b) b = cost(8'(w));
    return b;
  endfunction

  function automatic int clip8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_tap(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    if (sel == 0) th0 = val;
    else if (sel == 1) th1 = val;
    else if (sel == 2) th2 = val;
  endtask

  task automatic run_band(input bit gaps, output logic [7:0] got);
    int stray = 0;
    for (int t = 0; t < NT; t++) begin
      if (gaps && $urandom_range(0, 1) == 1) begin
        @(negedge clk);
        if (t > 0 && out_valid) stray++;
        in_valid = 1'b0; in_track = 3'($urandom_range(0, 7)); in_sample = 8'($urandom);
      end
      @(negedge clk);
      if (t > 0 && out_valid) stray++;
      in_valid = 1'b1; in_track = 3'(t); in_sample = 8'(smp[t]);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sample = 8'($urandom);
    chk(out_valid === 1'b1, "R7 strobe", int'(out_valid), 1);
    chk(stray == 0, "R7 early strobe", stray, 0);
    got = out_word;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 single cycle", int'(out_valid), 0);
    chk(out_word === got, "R8 word held", int'(out_word), int'(got));
  endtask

  task automatic band_exact(input logic [7:0] w, input bit gaps, input string req);
    logic [7:0] got;
    for (int t = 0; t < NT; t++) smp[t] = lvl(t, w);
    run_band(gaps, got);
    chk(got === w, req, int'(got), int'(w));
  endtask

  task automatic band_noisy(input bit wild);
    logic [7:0] got;
    logic [7:0] w = 8'($urandom);
    int bc;
    for (int t = 0; t < NT; t++) begin
      if (wild) smp[t] = int'($urandom_range(0, 255)) - 128;
      else      smp[t] = clip8(lvl(t, w) + int'($urandom_range(0, 18)) - 9);
    end
    run_band(1'b0, got);
    bc = best_cost();
    chk(cost(got) == bc, "R5 path cost", cost(got), bc);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid at reset", int'(out_valid), 0);
    chk(out_word === 8'd0, "R1 word at reset", int'(out_word), 0);
    rst_n = 1'b1;
    @(negedge clk);

    band_exact(8'hA5, 1'b0, "R1 default taps");
    band_exact(8'h00, 1'b0, "R4 all zero");
    band_exact(8'hFF, 1'b0, "R4 all one");
    band_exact(8'h01, 1'b0, "R6 first track is bit 0");
    band_exact(8'h80, 1'b0, "R6 last track is bit 7");
    band_exact(8'h3C, 1'b0, "R4 mixed");

    // R9: partial band of four tracks, then a fresh band
    for (int t = 0; t < NT; t++) smp[t] = lvl(t, 8'hFF);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      in_valid = 1'b1; in_track = 3'(t); in_sample = 8'(smp[t]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b0, "R9 no strobe for partial band", int'(out_valid), 0);
    band_exact(8'h12, 1'b0, "R9 restart discards partial band");

    band_exact(8'h6B, 1'b1, "R8 idle cycles ignored");
    band_exact(8'hC9, 1'b1, "R8 idle cycles ignored");

    write_tap(0, -4);
    write_tap(1, 2);
    write_tap(2, 6);
    band_exact(8'h5A, 1'b0, "R2 new taps");
    band_exact(8'hE1, 1'b0, "R2 new taps");
    write_tap(3, 50);
    band_exact(8'h97, 1'b0, "R2 select 3 ignored");

    // R3: a strong two-back tap makes the start-state assumption visible
    write_tap(0, 2);
    write_tap(1, 0);
    write_tap(2, 9);
    band_exact(8'h01, 1'b0, "R3 start bits zero");
    band_exact(8'h02, 1'b0, "R3 start bits zero");
    band_exact(8'hFE, 1'b0, "R3 start bits zero");

    write_tap(0, 3);
    write_tap(1, 5);
    write_tap(2, 3);
    for (int k = 0; k < 40; k++) band_noisy(1'b0);
    for (int k = 0; k < 10; k++) band_noisy(1'b1);
    for (int k = 0; k < 10; k++) band_exact(8'($urandom), 1'b1, "R4 random word");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule